// File: doc/BRIEF.md
# I2C Master FIFO DMA Request Generator

This block sits beside the FIFOs of an I2C master that runs burst transfers. It tells a DMA controller when it should move data. It drives a single-transfer request line and a four-byte burst request line. In transmit direction, the requests ask the DMA to top up the transmit FIFO. In receive direction, they ask the DMA to drain the receive FIFO.

Software may preload the transmit FIFO before it starts a burst. The block asks for nothing until a burst-start strobe loads its byte down-counter from the programmed burst length. Each DMA transfer strobe then removes one byte from the count. Once the count reaches zero, both request lines stay low until the next burst-start strobe. The counter is exposed as the remaining-byte output.

The FIFO storage and the DMA controller are modelled only by their fill levels and the transfer strobe. The request lines are combinational from the registered counter and the present inputs. They therefore react in the same cycle that a fill level changes.

Top module: `i2c_dma_req_gen`

## Requirements
- R1: After reset, `remaining` is 0 and both `sreq` and `breq` are low.
- R2: A cycle with `burst_go` high loads `remaining` with `burst_len` at the next clock edge. This happens even while a burst is in progress, and it wins over a transfer strobe in the same cycle.
- R3: A cycle with `xfer_stb` high, `dma_en` high, `burst_go` low and `remaining` nonzero lowers `remaining` by exactly one at the next edge. A strobe while `remaining` is 0 leaves it at 0.
- R4: While `remaining` is 0, `sreq` and `breq` are both low, whatever the fill levels.
- R5: With `rx_mode` = 0 (transmit), `dma_en` high and `remaining` nonzero, `sreq` is high exactly when `tx_fill` is below 8, the FIFO depth.
- R6: With `rx_mode` = 0, `dma_en` high and `remaining` nonzero, `breq` is high exactly when `remaining` is at least 4 and `tx_fill` is below `tx_trig`. A burst of fewer than four bytes thus raises only `sreq`.
- R7: With `rx_mode` = 1 (receive), `dma_en` high and `remaining` nonzero, `sreq` is high exactly when `rx_fill` is at least 1. An empty receive FIFO raises no request.
- R8: With `rx_mode` = 1, `dma_en` high and `remaining` nonzero, `breq` is high exactly when `rx_fill` is at least 4 and `remaining` is at least 4.
- R9: With `dma_en` low, both request lines are low. Transfer strobes leave `remaining` unchanged, while `burst_go` still loads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | DMA service enable |
| rx_mode | input | 1 | Direction: 0 transmit, 1 receive |
| burst_go | input | 1 | Burst-start strobe, loads the counter |
| burst_len | input | 8 | Programmed burst length in bytes |
| tx_fill | input | 4 | Transmit FIFO fill level, 0 to 8 |
| rx_fill | input | 4 | Receive FIFO fill level, 0 to 8 |
| tx_trig | input | 3 | Transmit burst threshold, 0 to 7 |
| xfer_stb | input | 1 | One byte moved by the DMA this cycle |
| sreq | output | 1 | Single-transfer request |
| breq | output | 1 | Four-byte burst request |
| remaining | output | 8 | Bytes still to move in the current burst |

## Verification
Two events can meet in one cycle: a burst-start strobe and a DMA transfer strobe. The random phase raises both strobes independently, so they often coincide, both mid-burst and with the count at one or zero. A directed case forces the collision on purpose. In each such cycle, the bench expects `remaining` to equal the new burst length on the next edge, with no decrement applied. A last transfer that empties the counter in one cycle is judged by the requests dropping in the following cycle.

// File: rtl/i2c_dma_pkg.sv
package i2c_dma_pkg;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    typedef struct packed {
        logic single;
        logic burst;
    } req_t;

endpackage

// File: rtl/i2c_dma_burst_cnt.sv
module i2c_dma_burst_cnt #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic             burst_go,
    input  logic [LEN_W-1:0] burst_len,
    input  logic             xfer_stb,
    output logic [LEN_W-1:0] count,
    output logic             live
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (burst_go) begin
            st_d.cnt = burst_len;
        end else if (dma_en && xfer_stb && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign live  = (st_q.cnt != '0);

endmodule

// File: rtl/i2c_dma_lane.sv
module i2c_dma_lane
    import i2c_dma_pkg::*;
#(
    parameter bit IS_RX      = 1'b0,
    parameter int FILL_W     = 4,
    parameter int TRIG_W     = 3,
    parameter int LEN_W      = 8,
    parameter int DEPTH      = 8,
    parameter int BURST_SIZE = 4
) (
    input  logic              allow,
    input  logic [FILL_W-1:0] fill,
    input  logic [TRIG_W-1:0] trig,
    input  logic [LEN_W-1:0]  count,
    output req_t              req
);

    localparam logic [FILL_W-1:0] FULL_LVL  = FILL_W'(DEPTH);
    localparam logic [FILL_W-1:0] BURST_LVL = FILL_W'(BURST_SIZE);
    localparam logic [LEN_W-1:0]  BURST_CNT = LEN_W'(BURST_SIZE);

    logic room_for_burst;
    assign room_for_burst = (count >= BURST_CNT);

    generate
        if (IS_RX) begin : g_rx
            logic unused_trig;
            assign unused_trig = ^trig;
            always_comb begin
                req.single = allow && (fill != '0);
                req.burst  = allow && room_for_burst && (fill >= BURST_LVL);
            end
        end else begin : g_tx
            always_comb begin
                req.single = allow && (fill < FULL_LVL);
                req.burst  = allow && room_for_burst && (fill < FILL_W'(trig));
            end
        end
    endgenerate

endmodule

// File: rtl/i2c_dma_req_gen.sv
module i2c_dma_req_gen
    import i2c_dma_pkg::*;
#(
    parameter int LEN_W      = 8,
    parameter int FILL_W     = 4,
    parameter int TRIG_W     = 3,
    parameter int DEPTH      = 8,
    parameter int BURST_SIZE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              rx_mode,
    input  logic              burst_go,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [FILL_W-1:0] tx_fill,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic [TRIG_W-1:0] tx_trig,
    input  logic              xfer_stb,
    output logic              sreq,
    output logic              breq,
    output logic [LEN_W-1:0]  remaining
);

    logic [LEN_W-1:0] count;
    logic             live;
    logic             allow;
    dir_e             dir;
    req_t             tx_req, rx_req, sel_req;

    i2c_dma_burst_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_en    (dma_en),
        .burst_go  (burst_go),
        .burst_len (burst_len),
        .xfer_stb  (xfer_stb),
        .count     (count),
        .live      (live)
    );

    assign allow = dma_en && live;
    assign dir   = dir_e'(rx_mode);

    i2c_dma_lane #(
        .IS_RX(1'b0), .FILL_W(FILL_W), .TRIG_W(TRIG_W), .LEN_W(LEN_W),
        .DEPTH(DEPTH), .BURST_SIZE(BURST_SIZE)
    ) u_tx (
        .allow (allow),
        .fill  (tx_fill),
        .trig  (tx_trig),
        .count (count),
        .req   (tx_req)
    );

    i2c_dma_lane #(
        .IS_RX(1'b1), .FILL_W(FILL_W), .TRIG_W(TRIG_W), .LEN_W(LEN_W),
        .DEPTH(DEPTH), .BURST_SIZE(BURST_SIZE)
    ) u_rx (
        .allow (allow),
        .fill  (rx_fill),
        .trig  (tx_trig),
        .count (count),
        .req   (rx_req)
    );

    always_comb begin
        unique case (dir)
            DIR_RX:  sel_req = rx_req;
            default: sel_req = tx_req;
        endcase
    end

    assign sreq      = sel_req.single;
    assign breq      = sel_req.burst;
    assign remaining = count;

endmodule

// File: rtl/i2c_dma_req_gen_chk.sv
module i2c_dma_req_gen_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_en,
    input logic             burst_go,
    input logic [LEN_W-1:0] burst_len,
    input logic             xfer_stb,
    input logic             sreq,
    input logic             breq,
    input logic [LEN_W-1:0] remaining
);

    // R2: burst start loads the counter
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        burst_go |=> remaining == $past(burst_len));

    // R3: one strobe removes exactly one byte
    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && xfer_stb && !burst_go && remaining != '0)
            |=> remaining == $past(remaining) - LEN_W'(1));

    // R3: counter does not wrap below zero
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining == '0 && !burst_go) |=> remaining == '0);

    // R4: an exhausted burst raises nothing
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining == '0) |-> (!sreq && !breq));

    // R6, R8: a burst request always comes with a single request
    a_r6_burst_with_single: assert property (@(posedge clk) disable iff (!rst_n)
        breq |-> sreq);

    // R9: disabled DMA sees no request and strobes are ignored
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> (!sreq && !breq));

    a_r9_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && !burst_go) |=> $stable(remaining));

endmodule

bind i2c_dma_req_gen i2c_dma_req_gen_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_en    (dma_en),
    .burst_go  (burst_go),
    .burst_len (burst_len),
    .xfer_stb  (xfer_stb),
    .sreq      (sreq),
    .breq      (breq),
    .remaining (remaining)
);

// File: tb/i2c_dma_req_gen_test.sv
module i2c_dma_req_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_en = 1'b0, rx_mode = 1'b0, burst_go = 1'b0, xfer_stb = 1'b0;
    logic [7:0] burst_len = '0;
    logic [3:0] tx_fill = '0, rx_fill = '0;
    logic [2:0] tx_trig = '0;
    logic       sreq, breq;
    logic [7:0] remaining;

    int unsigned total = 0, bad = 0;
    int unsigned model = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    i2c_dma_req_gen uut (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .rx_mode(rx_mode),
        .burst_go(burst_go), .burst_len(burst_len), .tx_fill(tx_fill),
        .rx_fill(rx_fill), .tx_trig(tx_trig), .xfer_stb(xfer_stb),
        .sreq(sreq), .breq(breq), .remaining(remaining)
    );

    function automatic bit exp_single(bit en, bit rx, int unsigned cnt,
                                      int unsigned tf, int unsigned rf);
        if (!en || cnt == 0) return 1'b0;
        if (rx) return rf >= 1;
        return tf < 8;
    endfunction

    function automatic bit exp_burst(bit en, bit rx, int unsigned cnt,
                                     int unsigned tf, int unsigned rf, int unsigned trig);
        if (!en || cnt == 0 || cnt < 4) return 1'b0;
        if (rx) return rf >= 4;
        return tf < trig;
    endfunction

    function automatic string tag_for(bit en, bit rx, int unsigned cnt, bit is_burst);
        if (!en) return "R9";
        if (cnt == 0) return "R4";
        if (rx) return is_burst ? "R8" : "R7";
        return is_burst ? "R6" : "R5";
    endfunction

    task automatic check(string tag, int unsigned act, int unsigned exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit go, bit en, bit rx, bit stb, int unsigned len,
                        int unsigned tf, int unsigned rf, int unsigned trig);
        burst_go  = go;
        dma_en    = en;
        rx_mode   = rx;
        xfer_stb  = stb;
        burst_len = 8'(len);
        tx_fill   = 4'(tf);
        rx_fill   = 4'(rf);
        tx_trig   = 3'(trig);
        #5;
        check(tag_for(en, rx, model, 1'b0), sreq, exp_single(en, rx, model, tf, rf));
        check(tag_for(en, rx, model, 1'b1), breq, exp_burst(en, rx, model, tf, rf, trig));
        check(en ? "R3" : "R9", remaining, model);
        @(posedge clk);
        if (go) model = len;
        else if (en && stb && model != 0) model = model - 1;
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        tx_fill = 4'd0;
        rx_fill = 4'd3;
        dma_en  = 1'b1;
        #25;
        // R1: reset state with DMA enabled and fill levels asking for service
        check("R1", remaining, 0);
        check("R1", sreq, 0);
        check("R1", breq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: strobes before any burst keep the counter at zero, no requests
        step(0, 1, 0, 1, 0, 0, 0, 7);
        step(0, 1, 1, 1, 0, 0, 8, 7);
        check("R3", remaining, 0);

        // R2: load a 6-byte transmit burst, TX FIFO preloaded to 5
        step(1, 1, 0, 0, 6, 5, 0, 3);
        check("R2", remaining, 6);
        step(0, 1, 0, 1, 6, 2, 0, 3);
        step(0, 1, 0, 1, 6, 8, 0, 3);
        // R2: reload mid-burst colliding with a strobe
        step(1, 1, 0, 1, 9, 1, 0, 4);
        check("R2", remaining, 9);

        // R6: short burst of 3 with empty FIFO raises single only
        step(1, 1, 0, 0, 3, 0, 0, 7);
        step(0, 1, 0, 1, 3, 0, 0, 7);
        check("R6", breq, 0);
        step(0, 1, 0, 1, 3, 8, 0, 7);
        step(0, 1, 0, 1, 3, 8, 0, 7);
        check("R4", remaining, 0);
        step(0, 1, 0, 1, 3, 0, 0, 7);

        // R9: DMA disabled freezes count, quiet lines
        step(1, 1, 1, 0, 5, 0, 6, 0);
        step(0, 0, 1, 1, 5, 0, 6, 0);
        step(0, 0, 1, 1, 5, 0, 6, 0);
        check("R9", remaining, 5);

        // R7/R8: receive drain
        step(0, 1, 1, 0, 5, 0, 0, 0);
        step(0, 1, 1, 1, 5, 0, 4, 0);
        step(0, 1, 1, 1, 5, 0, 3, 0);
        step(0, 1, 1, 1, 5, 0, 8, 0);
        step(0, 1, 1, 1, 5, 0, 8, 0);
        step(0, 1, 1, 1, 5, 0, 8, 0);
        check("R8", remaining, 0);
        step(0, 1, 1, 1, 5, 0, 8, 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit          go  = ($urandom % 16) == 0;
            bit          en  = ($urandom % 8) != 0;
            bit          rx  = ($urandom % 2) == 1;
            bit          stb = ($urandom % 2) == 1;
            int unsigned len = $urandom % 12;
            int unsigned tf  = $urandom % 9;
            int unsigned rf  = $urandom % 9;
            int unsigned tg  = $urandom % 8;
            step(go, en, rx, stb, len, tf, rf, tg);
        end

        summary();
    end

endmodule